// File: doc/BRIEF.md
# Automatic Chip Erase Sequencer

This block runs a complete erase of a word-organised non-volatile array once it is told to start. It works in two phases. First it drives every word to all zeros and reads each one back. A word that does not read back as zero is written again, up to a retry limit. Only after the last word has verified does the erase phase begin.

The erase phase applies a bulk erase strobe of fixed width to the whole array at once. It then reads the array back, looking for all-ones words. When a word still holds programmed bits, the block fires another pulse and resumes reading at that same word. It gives up once a pulse budget is spent.

The array sits outside the block and is reached through a simple port:
- a word write strobe;
- a read strobe, with read data returned on the following cycle;
- a bulk erase strobe.

A host sees the block through four outputs: busy, a one-cycle done pulse, a sticky fail flag, and a status bit that flips on each host status read while the sequence runs. Start requests that arrive while the block is busy have no effect.

Top module: `chip_erase_seq`

## Requirements
- R1: An `erase_start` seen while idle raises `busy` on the next cycle. The block then writes data 0x0000 to word addresses 0 to DEPTH-1 in ascending order. Each write is followed by one read of the same address, and that read must return 0x0000 before the next address is written.
- R2: A pre-program read that is not 0x0000 causes the same address to be written and read again. After PGM_TRIES failed reads at one address, the block raises `fail`, drops `busy` and ends without any erase pulse.
- R3: No bulk erase pulse starts until every word has passed its pre-program read.
- R4: Each erase pulse holds `arr_erase` high for exactly PULSE_CYC consecutive cycles.
- R5: After each pulse, the block reads words looking for 0xFFFF. After the first pulse it starts at address 0. A miss triggers another pulse, and reading then resumes at the missed address, not at 0.
- R6: At most MAX_PULSES pulses are issued. If a word still misses after the last allowed pulse, `fail` rises, `busy` falls, and `fail` stays high until the next accepted start.
- R7: When the last word reads 0xFFFF, `done` is high for exactly one cycle, in the cycle where `busy` has just fallen, with `fail` low.
- R8: While `busy` is high, each cycle with `status_rd` high inverts `toggle`. While idle, `status_rd` leaves `toggle` unchanged.
- R9: An `erase_start` while `busy` is high is ignored: the running sequence neither restarts nor changes.
- R10: After reset, `busy`, `done`, `fail`, `toggle` and all three array strobes are low.
- R11: In any cycle, at most one of `arr_wr_en`, `arr_rd_en` and `arr_erase` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_start | input | 1 | Request to begin a full erase (ignored while busy) |
| status_rd | input | 1 | Host status read strobe, flips `toggle` while busy |
| arr_rdata | input | DATA_W | Array read data, valid the cycle after `arr_rd_en` |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array write data (always zero) |
| arr_wr_en | output | 1 | Array word write strobe |
| arr_rd_en | output | 1 | Array read strobe |
| arr_erase | output | 1 | Bulk erase strobe for the whole array |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Sequence aborted; held until the next accepted start |
| toggle | output | 1 | Status bit flipped by status reads while busy |

## Verification
The bench builds the block with DEPTH 8, PULSE_CYC 5, MAX_PULSES 4 and PGM_TRIES 3. With these values a whole sequence takes a few dozen cycles. The array model can then mark single words that need extra writes or extra pulses, which reaches three cases in a short run:
- resuming after a verify miss;
- running out of pre-program retries;
- running out of pulses.

The scoreboard predicts the exact order of writes, reads, pulses and the ending from those per-word needs. Any restart, skipped address or extra pulse therefore shows up as a mismatch.

// File: rtl/ces_pkg.sv
package ces_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PP_WR,
    S_PP_RD,
    S_PP_CHK,
    S_ER_PULSE,
    S_EV_RD,
    S_EV_CHK
  } ces_state_t;
endpackage

// File: rtl/ces_width_timer.sv
// Down-counter that sets the width of one bulk erase pulse.
module ces_width_timer #(
  parameter int PULSE_CYC = 16,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(PULSE_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

  assert_timer_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(PULSE_CYC - 1));
endmodule

// File: rtl/ces_scan_addr.sv
// Word address counter shared by the pre-program and erase-verify scans.
module ces_scan_addr #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr_q <= '0;
    end else if (inc) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = (addr_q == ADDR_W'(DEPTH - 1));

  // R5: the scan never steps past the final word
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (addr_q != '0));
endmodule

// File: rtl/ces_status.sv
// Host-visible status registers: busy, done, fail and the toggle bit.
module ces_status (
  input  logic clk,
  input  logic rst,
  input  logic busy_nxt,
  input  logic done_set,
  input  logic fail_set,
  input  logic start_acc,
  input  logic status_rd,
  output logic busy,
  output logic done,
  output logic fail,
  output logic toggle
);
  logic busy_q, done_q, fail_q, toggle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      toggle_q <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      done_q <= done_set;
      if (start_acc) begin
        fail_q <= 1'b0;
      end else if (fail_set) begin
        fail_q <= 1'b1;
      end
      if (busy_q && status_rd) begin
        toggle_q <= ~toggle_q;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign fail   = fail_q;
  assign toggle = toggle_q;

  // R8: status reads while idle leave the toggle bit alone
  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_q) |-> $stable(toggle_q));

  // R7: a done pulse lasts one cycle and never coincides with busy or fail
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && !fail_q) ##1 !done_q);
endmodule

// File: rtl/chip_erase_seq.sv
// Whole-array erase sequencer: pre-program and verify, then pulse/verify loop.
module chip_erase_seq
  import ces_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 2097152,
  parameter int PULSE_CYC  = 5000000,
  parameter int MAX_PULSES = 1024,
  parameter int PGM_TRIES  = 25,
  localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_start,
  input  logic              status_rd,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_wr_en,
  output logic              arr_rd_en,
  output logic              arr_erase,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              toggle
);
  localparam int PCW = $clog2(MAX_PULSES + 1);
  localparam int TCW = $clog2(PGM_TRIES + 1);

  ces_state_t state_q, state_nxt;

  logic [PCW-1:0] pulse_q;
  logic [TCW-1:0] tries_q;
  logic scan_clr, scan_inc, scan_last;
  logic tmr_load, tmr_expire;
  logic pulse_inc, pulse_clr, try_inc, try_clr;
  logic done_set, fail_set, start_acc;
  logic word_zero, word_ones;

  assign word_zero = (arr_rdata == '0);
  assign word_ones = (arr_rdata == '1);

  ces_scan_addr #(.DEPTH(DEPTH)) u_scan (
    .clk  (clk),
    .rst  (rst),
    .clr  (scan_clr),
    .inc  (scan_inc),
    .addr (arr_addr),
    .last (scan_last)
  );

  ces_width_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .expire (tmr_expire)
  );

  ces_status u_status (
    .clk       (clk),
    .rst       (rst),
    .busy_nxt  (state_nxt != S_IDLE),
    .done_set  (done_set),
    .fail_set  (fail_set),
    .start_acc (start_acc),
    .status_rd (status_rd),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .toggle    (toggle)
  );

  always_comb begin
    state_nxt = state_q;
    scan_clr  = 1'b0;
    scan_inc  = 1'b0;
    tmr_load  = 1'b0;
    pulse_inc = 1'b0;
    pulse_clr = 1'b0;
    try_inc   = 1'b0;
    try_clr   = 1'b0;
    done_set  = 1'b0;
    fail_set  = 1'b0;
    start_acc = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (erase_start) begin
          start_acc = 1'b1;
          scan_clr  = 1'b1;
          pulse_clr = 1'b1;
          try_clr   = 1'b1;
          state_nxt = S_PP_WR;
        end
      end
      S_PP_WR: state_nxt = S_PP_RD;
      S_PP_RD: state_nxt = S_PP_CHK;
      S_PP_CHK: begin
        if (word_zero) begin
          try_clr = 1'b1;
          if (scan_last) begin
            scan_clr  = 1'b1;
            tmr_load  = 1'b1;
            pulse_inc = 1'b1;
            state_nxt = S_ER_PULSE;
          end else begin
            scan_inc  = 1'b1;
            state_nxt = S_PP_WR;
          end
        end else if (tries_q == TCW'(PGM_TRIES - 1)) begin
          fail_set  = 1'b1;
          state_nxt = S_IDLE;
        end else begin
          try_inc   = 1'b1;
          state_nxt = S_PP_WR;
        end
      end
      S_ER_PULSE: begin
        if (tmr_expire) state_nxt = S_EV_RD;
      end
      S_EV_RD: state_nxt = S_EV_CHK;
      S_EV_CHK: begin
        if (word_ones) begin
          if (scan_last) begin
            done_set  = 1'b1;
            state_nxt = S_IDLE;
          end else begin
            scan_inc  = 1'b1;
            state_nxt = S_EV_RD;
          end
        end else if (pulse_q == PCW'(MAX_PULSES)) begin
          fail_set  = 1'b1;
          state_nxt = S_IDLE;
        end else begin
          tmr_load  = 1'b1;
          pulse_inc = 1'b1;
          state_nxt = S_ER_PULSE;
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pulse_q <= '0;
      tries_q <= '0;
    end else begin
      state_q <= state_nxt;
      if (pulse_clr)      pulse_q <= '0;
      else if (pulse_inc) pulse_q <= pulse_q + 1'b1;
      if (try_clr)        tries_q <= '0;
      else if (try_inc)   tries_q <= tries_q + 1'b1;
    end
  end

  assign arr_wr_en = (state_q == S_PP_WR);
  assign arr_rd_en = (state_q == S_PP_RD) || (state_q == S_EV_RD);
  assign arr_erase = (state_q == S_ER_PULSE);
  assign arr_wdata = '0;

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_wr_en, arr_rd_en, arr_erase}));

  assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_q <= PCW'(MAX_PULSES));

  assert_erase_after_check_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_erase) |-> ($past(state_q) == S_PP_CHK || $past(state_q) == S_EV_CHK));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != S_IDLE && erase_start) |=> !$rose(arr_wr_en) || $past(state_q) == S_PP_CHK);
endmodule

// File: tb/chip_erase_seq_tb.sv
`timescale 1ns/1ps
module chip_erase_seq_tb;
  localparam int DW = 16, DEPTH = 8, AW = 3, PC = 5, MAXP = 4, PT = 3;

  logic clk = 1'b0, rst = 1'b1, erase_start = 1'b0, status_rd = 1'b0;
  logic [DW-1:0] arr_rdata = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic arr_wr_en, arr_rd_en, arr_erase, busy, done, fail, toggle;

  always #2 clk = ~clk;

  chip_erase_seq #(.DATA_W(DW), .DEPTH(DEPTH), .PULSE_CYC(PC),
                   .MAX_PULSES(MAXP), .PGM_TRIES(PT)) u_dut (
    .clk(clk), .rst(rst), .erase_start(erase_start), .status_rd(status_rd),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_wr_en(arr_wr_en), .arr_rd_en(arr_rd_en), .arr_erase(arr_erase),
    .busy(busy), .done(done), .fail(fail), .toggle(toggle));

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  // array model: per-word write and pulse needs
  logic [DW-1:0] mem [DEPTH];
  int wneed [DEPTH];
  int eneed [DEPTH];
  int wcnt  [DEPTH];
  int pulses_seen = 0;
  logic model_eq = 1'b0;

  always @(posedge clk) begin
    if (arr_wr_en) begin
      wcnt[arr_addr] = wcnt[arr_addr] + 1;
      if (wcnt[arr_addr] >= wneed[arr_addr]) mem[arr_addr] = arr_wdata;
    end
    if (arr_rd_en) arr_rdata = mem[arr_addr];
    if (arr_erase && !model_eq) begin
      pulses_seen = pulses_seen + 1;
      for (int i = 0; i < DEPTH; i++)
        if (pulses_seen >= eneed[i]) mem[i] = '1;
    end
    model_eq = arr_erase;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic string ev_req(input int typ);
    case (typ)
      0: return "R1 R2 pre-program write";
      1: return "R1 R5 verify read";
      2: return "R3 R5 erase pulse";
      default: return "R6 R7 ending";
    endcase
  endfunction

  task automatic expect_ev(input int typ, input int dat);
    int got = typ * 65536 + dat;
    if (exp_q.size() == 0) begin
      check(1'b0, {ev_req(typ), " unexpected"}, got, -1);
    end else begin
      int e = exp_q.pop_front();
      check(got == e, ev_req(typ), got, e);
    end
  endtask

  // monitor
  logic mon_e = 1'b0, mon_f = 1'b0;
  int ewidth = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (arr_wr_en) begin
        expect_ev(0, int'(arr_addr));
        check(arr_wdata == '0, "R1 write data", int'(arr_wdata), 0);
      end
      if (arr_rd_en) expect_ev(1, int'(arr_addr));
      if (arr_erase && !mon_e) expect_ev(2, 0);
      if (arr_erase) ewidth++;
      else if (mon_e) begin
        check(ewidth == PC, "R4 pulse width", ewidth, PC);
        ewidth = 0;
      end
      if (done) expect_ev(3, 1);
      if (fail && !mon_f) expect_ev(3, 0);
      mon_e = arr_erase;
      mon_f = fail;
    end
  end

  // driver: prepare model and push expected events
  task automatic prepare();
    bit ok = 1'b1;
    int p;
    int a;
    pulses_seen = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'h5A5A;
      wcnt[i] = 0;
    end
    for (int i = 0; i < DEPTH && ok; i++) begin
      for (int t = 1; t <= PT; t++) begin
        exp_q.push_back(i);
        exp_q.push_back(65536 + i);
        if (t >= wneed[i]) break;
        if (t == PT) ok = 1'b0;
      end
    end
    if (ok) begin
      p = 1;
      exp_q.push_back(2 * 65536);
      a = 0;
      while (a < DEPTH && ok) begin
        exp_q.push_back(65536 + a);
        if (p >= eneed[a]) a++;
        else if (p == MAXP) ok = 1'b0;
        else begin
          p++;
          exp_q.push_back(2 * 65536);
        end
      end
    end
    exp_q.push_back(3 * 65536 + (ok ? 1 : 0));
  endtask

  task automatic set_needs(input int w, input int e);
    for (int i = 0; i < DEPTH; i++) begin
      wneed[i] = w;
      eneed[i] = e;
    end
  endtask

  task automatic launch();
    @(negedge clk) erase_start = 1'b1;
    @(negedge clk) erase_start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
  endtask

  task automatic finish(input bit exp_fail, input string req);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {req, " events left"}, exp_q.size(), 0);
    check(fail == exp_fail, {req, " fail flag"}, int'(fail), int'(exp_fail));
    check(busy == 1'b0, {req, " busy low"}, int'(busy), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit t0;
    set_needs(1, 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({busy, done, fail, toggle} == 4'b0, "R10 status after reset",
          int'({busy, done, fail, toggle}), 0);
    check({arr_wr_en, arr_rd_en, arr_erase} == 3'b0, "R10 strobes after reset",
          int'({arr_wr_en, arr_rd_en, arr_erase}), 0);

    // plain run, with toggle reads and an ignored start (R8, R9)
    set_needs(1, 1);
    prepare();
    launch();
    t0 = toggle;
    status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
    check(toggle == ~t0, "R8 toggle flips while busy", int'(toggle), int'(~t0));
    status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
    check(toggle == t0, "R8 toggle flips back", int'(toggle), int'(t0));
    repeat (4) @(negedge clk);
    erase_start = 1'b1;
    @(negedge clk) erase_start = 1'b0;
    finish(1'b0, "R9 R7 plain run");
    t0 = toggle;
    status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
    @(negedge clk);
    check(toggle == t0, "R8 toggle held while idle", int'(toggle), int'(t0));

    // stubborn words: resume at failing address (R5)
    set_needs(1, 1);
    eneed[2] = 2;
    eneed[5] = 3;
    prepare();
    launch();
    finish(1'b0, "R5 resume run");

    // pulse budget exhausted (R6)
    set_needs(1, 1);
    eneed[3] = 6;
    prepare();
    launch();
    finish(1'b1, "R6 pulse limit");

    // one retry succeeds (R2)
    set_needs(1, 1);
    wneed[1] = 2;
    prepare();
    launch();
    finish(1'b0, "R2 retry ok");

    // retries exhausted, no pulse (R2 R3)
    set_needs(1, 1);
    wneed[4] = 5;
    prepare();
    launch();
    finish(1'b1, "R2 R3 retry limit");

    // fail clears on a new accepted start (R6)
    set_needs(1, 1);
    prepare();
    launch();
    check(fail == 1'b0, "R6 fail cleared by start", int'(fail), 0);
    finish(1'b0, "R6 clean run after fail");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule